// File: doc/BRIEF.md
# Sector-Aligned DMA Segment Splitter

This block sits between a host DMA channel and a storage device that only moves whole 512-byte sectors. Each host descriptor carries a byte address and a byte length that need not be a sector multiple. The block cuts every descriptor into three parts. The first is a head that finishes a sector left open by the previous descriptor. The second is a bulk run of whole sectors, issued as one storage request. The third is a tail that opens a new sector. Head and tail bytes pass through a one-sector bounce buffer. That buffer is the only place where a partial sector is held between descriptors.

A command is started with a direction, a first sector number and a sector count. While a command is active, descriptors are taken one at a time. The block moves the current sector forward and reduces the remaining count as bulk work completes. The command ends when no sectors remain and no partial sector is pending. At that point a success flag is set and a one-cycle interrupt pulse is raised. A storage error aborts the command instead and sets an error flag. Descriptors presented while no command is active wait on the handshake.

The storage side is a request/acknowledge port that carries a sector number, a sector count, the direction, the host address and a flag marking bounce-buffer requests. During a bounce request, the storage reads or fills the buffer through a byte index port. Host bytes for head and tail move over a byte-wide valid/ready memory port.

Top module: `sds_splitter`

States of the controller:
- IDLE waits for a descriptor.
- HEAD copies pending remainder bytes.
- FLUSH writes the completed bounce sector back.
- CHECK decides between completion, end of descriptor, tail handling and bulk.
- FETCH loads the tail sector.
- TAIL copies tail bytes.
- BULK issues the whole-sector request.
- ADV advances the sector bookkeeping.
- ABORT handles an error.
- DONE signals the end of a descriptor.

Transitions:
- IDLE goes to HEAD when a remainder is pending and the length is non-zero, and to CHECK otherwise.
- HEAD goes to FLUSH on a write, or to CHECK on a read.
- FLUSH goes to CHECK.
- CHECK goes to DONE, to TAIL on a write, to FETCH on a read, or to BULK.
- FETCH goes to TAIL.
- TAIL goes to BULK if the bulk is non-zero, and to ADV otherwise.
- BULK goes to ADV.
- ADV goes to CHECK.
- FLUSH, FETCH and BULK go to ABORT when the acknowledge carries an error.
- ABORT goes to DONE.
- DONE goes to IDLE.

## Requirements
- R1: After reset, desc_ready, stor_req, mem_valid, irq, cmd_ok and cmd_err are all 0.
- R2: A descriptor is accepted (desc_ready=1) only while a command is active. Without an active command, no storage or memory traffic occurs.
- R3: A descriptor whose length is a multiple of 512 produces exactly one bulk request (stor_bounce=0). That request has stor_sector equal to the current sector, stor_count equal to length/512 and stor_addr equal to the descriptor address.
- R4: On a read whose tail t = len mod 512 is non-zero, the sector just after the bulk range is fetched into the bounce buffer. This fetch is a request with stor_bounce=1, stor_write=0 and stor_count=1. Buffer bytes 0..t-1 are then written to the last t bytes of the descriptor region.
- R5: On a write whose tail t is non-zero, the last t bytes of the descriptor region are captured into buffer bytes 0..t-1. In both directions the pending remainder becomes (512 - t) mod 512.
- R6: When a remainder r is pending, the next descriptor first handles min(r, len) bytes at buffer offset 512 - r. On a write, the buffer is then written to the current sector minus 1, with stor_bounce=1, stor_write=1 and stor_count=1. Address, length and remainder all shift by the bytes handled.
- R7: After bulk handling, the current sector advances by ceil(L/512) and the remaining count drops by the same amount, capped at the remaining count. L is the descriptor length left after the head.
- R8: The command completes only when the remaining count is 0 and no remainder is pending. On completion cmd_ok is set, irq pulses for exactly one cycle and the command becomes inactive.
- R9: If a descriptor's bulk length is zero, no bulk request is issued and bookkeeping proceeds as if it had completed.
- R10: An acknowledge with stor_err aborts the command. The pending remainder is cleared, cmd_err is set, cmd_ok stays 0 and no irq is raised.
- R11: A raised stor_req or mem_valid keeps its request fields stable until it is acknowledged or accepted.
- R12: A command start clears cmd_ok and cmd_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start a command (taken while idle and inactive) |
| cmd_write | input | 1 | 1 = host to storage, 0 = storage to host |
| cmd_sector | input | SECT_W | First sector of the command |
| cmd_count | input | CNT_W | Sector count of the command |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken this cycle |
| desc_addr | input | ADDR_W | Descriptor host byte address |
| desc_len | input | LEN_W | Descriptor byte length |
| desc_done | output | 1 | One-cycle pulse when a descriptor is finished |
| stor_req | output | 1 | Storage request |
| stor_write | output | 1 | Storage request direction, 1 = write to medium |
| stor_bounce | output | 1 | Request uses the bounce buffer (one sector) |
| stor_sector | output | SECT_W | Sector number of the request |
| stor_count | output | CNT_W | Sector count of the request |
| stor_addr | output | ADDR_W | Host address for bulk requests |
| stor_ack | input | 1 | Request finished |
| stor_err | input | 1 | Request failed (valid with stor_ack) |
| buf_idx | input | SEC_BITS | Storage-side bounce buffer byte index |
| buf_we | input | 1 | Storage-side bounce write (honoured during a fetch only) |
| buf_wdata | input | 8 | Storage-side bounce write data |
| buf_rdata | output | 8 | Storage-side bounce read data |
| mem_valid | output | 1 | Host byte access request |
| mem_we | output | 1 | 1 = write host byte |
| mem_addr | output | ADDR_W | Host byte address |
| mem_wdata | output | 8 | Host write data |
| mem_rdata | input | 8 | Host read data, valid with mem_ready |
| mem_ready | input | 1 | Host access accepted |
| cmd_ok | output | 1 | Command completed successfully |
| cmd_err | output | 1 | Command aborted by a storage error |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Reads and writes are tried with three kinds of descriptor pattern:
- A single aligned descriptor, which isolates the bulk path.
- A chain that opens a sector and closes it over two tiny descriptors before an aligned one. This separates correct head offsets and sector advance from errors off by one sector.
- A descriptor shorter than a sector, which shows that the bulk request is skipped.

The write chain shows that the write-back lands on the sector before the current one. An error that occurs with a remainder pending is followed by a new aligned command. Corrupted data in that command would expose a remainder that was not cleared. Completion is observed after every descriptor, so a premature success or interrupt is caught.

// File: rtl/sds_pkg.sv
package sds_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_FLUSH,
        ST_CHECK,
        ST_FETCH,
        ST_TAIL,
        ST_BULK,
        ST_ADV,
        ST_ABORT,
        ST_DONE
    } sds_state_e;
endpackage

// File: rtl/sds_bounce_buf.sv
module sds_bounce_buf #(
    parameter int SEC_BITS = 9
) (
    input  logic                clk,
    input  logic [SEC_BITS-1:0] a_idx,
    input  logic                a_we,
    input  logic [7:0]          a_wdata,
    output logic [7:0]          a_rdata,
    input  logic [SEC_BITS-1:0] b_idx,
    input  logic                b_we,
    input  logic [7:0]          b_wdata,
    output logic [7:0]          b_rdata
);
    localparam int DEPTH = 1 << SEC_BITS;

    logic [7:0] store [DEPTH];

    // Port A (controller) wins a same-cycle write; the two never overlap in use.
    always_ff @(posedge clk) begin
        if (a_we) begin
            store[a_idx] <= a_wdata;
        end else if (b_we) begin
            store[b_idx] <= b_wdata;
        end
    end

    assign a_rdata = store[a_idx];
    assign b_rdata = store[b_idx];
endmodule

// File: rtl/sds_seg_math.sv
module sds_seg_math #(
    parameter int SEC_BITS = 9,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16
) (
    input  logic [LEN_W-1:0]          len,
    input  logic [LEN_W-1:0]          launch_len,
    input  logic [SEC_BITS-1:0]       rem,
    input  logic [CNT_W-1:0]          cnt,
    output logic [SEC_BITS-1:0]       tail,
    output logic [SEC_BITS-1:0]       new_rem,
    output logic [SEC_BITS-1:0]       head,
    output logic [LEN_W-SEC_BITS-1:0] bulk_secs,
    output logic [CNT_W-1:0]          adv
);
    localparam int BS_W = LEN_W - SEC_BITS;
    localparam logic [SEC_BITS-1:0] ONE_S = SEC_BITS'(1);

    logic [BS_W:0]      ceil_secs;
    logic [CNT_W-1:0]   ceil_ext;

    assign tail      = len[SEC_BITS-1:0];
    // (sector - tail) mod sector == two's complement of tail
    assign new_rem   = ~tail + ONE_S;
    assign bulk_secs = len[LEN_W-1:SEC_BITS];
    assign head      = (len < {{BS_W{1'b0}}, rem}) ? len[SEC_BITS-1:0] : rem;

    assign ceil_secs = {1'b0, launch_len[LEN_W-1:SEC_BITS]}
                     + {{BS_W{1'b0}}, |launch_len[SEC_BITS-1:0]};
    assign ceil_ext  = CNT_W'(ceil_secs);
    assign adv       = (ceil_ext < cnt) ? ceil_ext : cnt;
endmodule

// File: rtl/sds_splitter.sv
module sds_splitter #(
    parameter int SEC_BITS = 9,
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int SECT_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_write,
    input  logic [SECT_W-1:0]   cmd_sector,
    input  logic [CNT_W-1:0]    cmd_count,
    input  logic                desc_valid,
    output logic                desc_ready,
    input  logic [ADDR_W-1:0]   desc_addr,
    input  logic [LEN_W-1:0]    desc_len,
    output logic                desc_done,
    output logic                stor_req,
    output logic                stor_write,
    output logic                stor_bounce,
    output logic [SECT_W-1:0]   stor_sector,
    output logic [CNT_W-1:0]    stor_count,
    output logic [ADDR_W-1:0]   stor_addr,
    input  logic                stor_ack,
    input  logic                stor_err,
    input  logic [SEC_BITS-1:0] buf_idx,
    input  logic                buf_we,
    input  logic [7:0]          buf_wdata,
    output logic [7:0]          buf_rdata,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata,
    input  logic                mem_ready,
    output logic                cmd_ok,
    output logic                cmd_err,
    output logic                irq
);
    import sds_pkg::*;

    localparam int BS_W = LEN_W - SEC_BITS;
    localparam logic [SEC_BITS-1:0] ONE_S = SEC_BITS'(1);

    sds_state_e state, nxt;

    logic                active, dir_wr;
    logic [SECT_W-1:0]   sec_num;
    logic [CNT_W-1:0]    sec_cnt;
    logic [SEC_BITS-1:0] rem, idx, loop_len;
    logic [ADDR_W-1:0]   cur_addr;
    logic [LEN_W-1:0]    cur_len, launch_len;

    logic [SEC_BITS-1:0] tail, new_rem, head, a_idx;
    logic [BS_W-1:0]     bulk_secs;
    logic [CNT_W-1:0]    adv;
    logic                a_we, beat, loop_last, finish;
    logic [7:0]          a_rdata;

    sds_seg_math #(.SEC_BITS(SEC_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_math (
        .len(cur_len), .launch_len(launch_len), .rem(rem), .cnt(sec_cnt),
        .tail(tail), .new_rem(new_rem), .head(head),
        .bulk_secs(bulk_secs), .adv(adv)
    );

    sds_bounce_buf #(.SEC_BITS(SEC_BITS)) u_buf (
        .clk(clk),
        .a_idx(a_idx), .a_we(a_we), .a_wdata(mem_rdata), .a_rdata(a_rdata),
        .b_idx(buf_idx), .b_we(buf_we && (state == ST_FETCH)),
        .b_wdata(buf_wdata), .b_rdata(buf_rdata)
    );

    assign beat      = mem_valid && mem_ready;
    assign loop_last = (idx == loop_len - ONE_S);
    assign finish    = (sec_cnt == '0) && (rem == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (active && desc_valid)
                          nxt = (rem != '0 && desc_len != '0) ? ST_HEAD : ST_CHECK;
            ST_HEAD:  if (beat && loop_last) nxt = dir_wr ? ST_FLUSH : ST_CHECK;
            ST_FLUSH: if (stor_ack) nxt = stor_err ? ST_ABORT : ST_CHECK;
            ST_CHECK: begin
                if (finish || cur_len == '0) nxt = ST_DONE;
                else if (tail != '0)          nxt = dir_wr ? ST_TAIL : ST_FETCH;
                else                          nxt = ST_BULK;
            end
            ST_FETCH: if (stor_ack) nxt = stor_err ? ST_ABORT : ST_TAIL;
            ST_TAIL:  if (beat && loop_last) nxt = (bulk_secs != '0) ? ST_BULK : ST_ADV;
            ST_BULK:  if (stor_ack) nxt = stor_err ? ST_ABORT : ST_ADV;
            ST_ADV:   nxt = ST_CHECK;
            ST_ABORT: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        desc_ready  = (state == ST_IDLE) && active;
        desc_done   = (state == ST_DONE);
        stor_req    = 1'b0;
        stor_write  = 1'b0;
        stor_bounce = 1'b1;
        stor_sector = '0;
        stor_count  = CNT_W'(1);
        stor_addr   = cur_addr;
        mem_valid   = 1'b0;
        mem_we      = !dir_wr;
        mem_addr    = '0;
        a_idx       = idx;
        loop_len    = tail;
        unique case (state)
            ST_HEAD: begin
                mem_valid = 1'b1;
                mem_addr  = cur_addr + ADDR_W'(idx);
                a_idx     = idx - rem;
                loop_len  = head;
            end
            ST_TAIL: begin
                mem_valid = 1'b1;
                mem_addr  = cur_addr + ADDR_W'(cur_len) - ADDR_W'(tail) + ADDR_W'(idx);
            end
            ST_FLUSH: begin
                stor_req    = 1'b1;
                stor_write  = 1'b1;
                stor_sector = sec_num - SECT_W'(1);
            end
            ST_FETCH: begin
                stor_req    = 1'b1;
                stor_sector = sec_num + SECT_W'(bulk_secs);
            end
            ST_BULK: begin
                stor_req    = 1'b1;
                stor_bounce = 1'b0;
                stor_write  = dir_wr;
                stor_sector = sec_num;
                stor_count  = CNT_W'(bulk_secs);
            end
            default: ;
        endcase
        a_we      = mem_valid && mem_ready && dir_wr;
        mem_wdata = a_rdata;
    end

    // Datapath and bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active     <= 1'b0;
            dir_wr     <= 1'b0;
            sec_num    <= '0;
            sec_cnt    <= '0;
            rem        <= '0;
            idx        <= '0;
            cur_addr   <= '0;
            cur_len    <= '0;
            launch_len <= '0;
            cmd_ok     <= 1'b0;
            cmd_err    <= 1'b0;
            irq        <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start && !active) begin
                        active  <= 1'b1;
                        dir_wr  <= cmd_write;
                        sec_num <= cmd_sector;
                        sec_cnt <= cmd_count;
                        cmd_ok  <= 1'b0;
                        cmd_err <= 1'b0;
                    end else if (active && desc_valid) begin
                        cur_addr <= desc_addr;
                        cur_len  <= desc_len;
                        idx      <= '0;
                    end
                end
                ST_HEAD: if (beat) begin
                    if (loop_last) begin
                        idx      <= '0;
                        cur_addr <= cur_addr + ADDR_W'(head);
                        cur_len  <= cur_len - LEN_W'(head);
                        rem      <= rem - head;
                    end else begin
                        idx <= idx + ONE_S;
                    end
                end
                ST_TAIL: if (beat) begin
                    if (loop_last) begin
                        idx     <= '0;
                        rem     <= new_rem;
                        cur_len <= cur_len - LEN_W'(tail);
                    end else begin
                        idx <= idx + ONE_S;
                    end
                end
                ST_CHECK: begin
                    if (finish) begin
                        cmd_ok <= 1'b1;
                        irq    <= 1'b1;
                        active <= 1'b0;
                    end else begin
                        launch_len <= cur_len;
                    end
                end
                ST_ADV: begin
                    sec_num <= sec_num + SECT_W'(adv);
                    sec_cnt <= sec_cnt - adv;
                    cur_len <= '0;
                end
                ST_ABORT: begin
                    cmd_err <= 1'b1;
                    rem     <= '0;
                    active  <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sds_splitter_chk.sv
module sds_splitter_chk #(
    parameter int SECT_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_ready,
    input logic              desc_done,
    input logic              stor_req,
    input logic              stor_ack,
    input logic              stor_write,
    input logic              stor_bounce,
    input logic [SECT_W-1:0] stor_sector,
    input logic [CNT_W-1:0]  stor_count,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cmd_ok,
    input logic              cmd_err,
    input logic              irq
);
    p_hold_stor_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stor_req && !stor_ack |=> stor_req && $stable(stor_sector)
                                  && $stable(stor_count) && $stable(stor_write));

    p_hold_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

    p_bounce_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stor_req && stor_bounce |-> stor_count == CNT_W'(1));

    p_bulk_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stor_req && !stor_bounce |-> stor_count != '0);

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_with_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmd_ok);

    p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !cmd_ok && !irq);

    p_ready_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !cmd_ok && !cmd_err);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done);
endmodule

bind sds_splitter sds_splitter_chk #(.SECT_W(SECT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .desc_done(desc_done),
    .stor_req(stor_req), .stor_ack(stor_ack), .stor_write(stor_write),
    .stor_bounce(stor_bounce), .stor_sector(stor_sector), .stor_count(stor_count),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .cmd_ok(cmd_ok), .cmd_err(cmd_err), .irq(irq)
);

// File: tb/tb_sds_splitter.sv
`timescale 1ns/1ps
module tb_sds_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, cmd_write = 0;
    logic [31:0] cmd_sector = 0;
    logic [15:0] cmd_count = 0;
    logic        desc_valid = 0;
    logic        desc_ready, desc_done;
    logic [31:0] desc_addr = 0;
    logic [15:0] desc_len = 0;
    logic        stor_req, stor_write, stor_bounce;
    logic [31:0] stor_sector, stor_addr;
    logic [15:0] stor_count;
    logic        stor_ack = 0, stor_err = 0;
    logic [8:0]  buf_idx = 0;
    logic        buf_we = 0;
    logic [7:0]  buf_wdata = 0, buf_rdata;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        cmd_ok, cmd_err, irq;

    always #2.5 clk = ~clk;

    sds_splitter dut (.*);

    // Behavioural host memory and medium
    logic [7:0] hmem [0:8191];
    logic [7:0] disk [0:32767];
    int rdy_cnt = 0;
    assign mem_rdata = hmem[mem_addr[12:0]];
    assign mem_ready = (rdy_cnt % 4) != 3;
    always @(negedge clk) rdy_cnt++;
    always @(posedge clk) if (mem_valid && mem_ready && mem_we) hmem[mem_addr[12:0]] = mem_wdata;

    int total = 0, bad = 0, irq_cnt = 0, cyc = 0;
    int q_sec[$], q_cnt[$], q_bnc[$], q_wr[$];
    bit err_arm = 0;

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Storage model: serves requests, logs them
    initial begin
        forever begin
            @(negedge clk);
            if (stor_req) begin
                automatic int sec = stor_sector, cnt = stor_count, a = stor_addr;
                automatic bit wr = stor_write, bnc = stor_bounce, e = 0;
                q_sec.push_back(sec); q_cnt.push_back(cnt);
                q_bnc.push_back(bnc); q_wr.push_back(wr);
                if (err_arm && !bnc) begin
                    e = 1; err_arm = 0;
                end else if (bnc && !wr) begin
                    for (int j = 0; j < 512; j++) begin
                        buf_idx = 9'(j); buf_we = 1; buf_wdata = disk[sec*512 + j];
                        @(negedge clk);
                    end
                    buf_we = 0;
                end else if (bnc && wr) begin
                    for (int j = 0; j < 512; j++) begin
                        buf_idx = 9'(j); #1;
                        disk[sec*512 + j] = buf_rdata;
                        @(negedge clk);
                    end
                end else begin
                    for (int j = 0; j < cnt*512; j++) begin
                        if (wr) disk[sec*512 + j] = hmem[(a + j) % 8192];
                        else    hmem[(a + j) % 8192] = disk[sec*512 + j];
                    end
                    @(negedge clk);
                end
                stor_ack = 1; stor_err = e;
                @(negedge clk);
                stor_ack = 0; stor_err = 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic start_cmd(input bit wr, input int sec, input int cnt);
        @(negedge clk);
        cmd_start = 1; cmd_write = wr; cmd_sector = sec; cmd_count = 16'(cnt);
        @(negedge clk);
        cmd_start = 0;
        q_sec.delete(); q_cnt.delete(); q_bnc.delete(); q_wr.delete();
        irq_cnt = 0;
    endtask

    task automatic do_desc(input int a, input int l);
        @(negedge clk);
        desc_addr = a; desc_len = 16'(l); desc_valid = 1;
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        desc_valid = 0;
        while (!desc_done) @(negedge clk);
        @(negedge clk);
    endtask

    // Compare a host region with the medium stream of the command
    task automatic chk_stream(input int a, input int l, input int dsk, input string tag);
        automatic int mis = 0, fa = 0, fe = 0;
        for (int j = 0; j < l; j++)
            if (hmem[a + j] !== disk[dsk + j]) begin
                if (mis == 0) begin fa = hmem[a + j]; fe = disk[dsk + j]; end
                mis++;
            end
        check(mis == 0, tag, fa, fe);
    endtask

    int nb;
    initial begin
        for (int i = 0; i < 32768; i++) disk[i] = 8'((i * 13) + (i >> 9));
        for (int i = 0; i < 8192; i++) hmem[i] = 8'(i * 5 + 1);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!desc_ready && !stor_req && !mem_valid && !irq && !cmd_ok && !cmd_err,
              "R1 reset outputs", {desc_ready, stor_req, mem_valid, irq, cmd_ok, cmd_err}, 0);
        rst_n = 1;
        // R2: no command -> descriptor stalls, no traffic
        @(negedge clk);
        desc_valid = 1; desc_addr = 32'h100; desc_len = 16'd512;
        nb = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (desc_ready || stor_req || mem_valid) nb++;
        end
        desc_valid = 0;
        check(nb == 0, "R2 stall without command", nb, 0);

        // R3: aligned read, one bulk
        start_cmd(0, 4, 2);
        do_desc(32'h100, 1024);
        chk_stream(32'h100, 1024, 4*512, "R3 aligned read data");
        check(q_sec.size() == 1 && q_bnc[0] == 0 && q_sec[0] == 4 && q_cnt[0] == 2,
              "R3 single bulk request", q_sec.size() > 0 ? q_cnt[0] : -1, 2);
        check(cmd_ok == 1 && irq_cnt == 1, "R8 completion and one irq", irq_cnt, 1);
        check(desc_ready == 0, "R2 inactive after completion", desc_ready, 0);

        // R4/R6/R7: read chain 1000, 10, 14, 512 from sector 10, 3 sectors
        start_cmd(0, 10, 3);
        check(cmd_ok == 0, "R12 start clears ok", cmd_ok, 0);
        do_desc(32'h800, 1000);
        check(q_bnc[0] == 1 && q_wr[0] == 0 && q_sec[0] == 11, "R4 tail sector fetch", q_sec[0], 11);
        check(cmd_ok == 0, "R8 not complete with remainder", cmd_ok, 0);
        do_desc(32'hC00, 10);
        do_desc(32'hD00, 14);
        check(cmd_ok == 0 && irq_cnt == 0, "R8 not complete with sectors left", cmd_ok, 0);
        do_desc(32'hE00, 512);
        check(q_bnc[q_bnc.size()-1] == 0 && q_sec[q_sec.size()-1] == 12,
              "R7 sector advance by ceil", q_sec[q_sec.size()-1], 12);
        chk_stream(32'h800, 1000, 10*512,        "R4 read chain part 1");
        chk_stream(32'hC00, 10,   10*512 + 1000, "R6 read head part 2");
        chk_stream(32'hD00, 14,   10*512 + 1010, "R6 read head part 3");
        chk_stream(32'hE00, 512,  10*512 + 1024, "R7 read chain part 4");
        check(cmd_ok == 1 && irq_cnt == 1, "R8 chain completes", irq_cnt, 1);

        // R5/R6: write 700 + 324 to sector 20, 2 sectors
        start_cmd(1, 20, 2);
        do_desc(32'h1000, 700);
        check(cmd_ok == 0, "R5 write remainder keeps command open", cmd_ok, 0);
        do_desc(32'h1400, 324);
        nb = q_sec.size();
        check(q_bnc[nb-1] == 1 && q_wr[nb-1] == 1 && q_sec[nb-1] == 21,
              "R6 write-back to sector minus one", q_sec[nb-1], 21);
        chk_stream(32'h1000, 700, 20*512,       "R5 written data part 1");
        chk_stream(32'h1400, 324, 20*512 + 700, "R6 written data part 2");
        check(cmd_ok == 1 && irq_cnt == 1, "R8 write completes", irq_cnt, 1);

        // R9: descriptors shorter than a sector
        start_cmd(0, 30, 1);
        do_desc(32'h1800, 100);
        do_desc(32'h1900, 412);
        nb = 0;
        foreach (q_bnc[i]) if (q_bnc[i] == 0) nb++;
        check(nb == 0, "R9 no bulk request for zero bulk", nb, 0);
        chk_stream(32'h1800, 100, 30*512,       "R9 short read part 1");
        chk_stream(32'h1900, 412, 30*512 + 100, "R9 short read part 2");
        check(cmd_ok == 1, "R9 short chain completes", cmd_ok, 1);

        // R10: error on bulk with remainder pending
        start_cmd(0, 40, 2);
        err_arm = 1;
        do_desc(32'h1A00, 700);
        check(cmd_err == 1 && cmd_ok == 0, "R10 error flag", cmd_err, 1);
        check(irq_cnt == 0, "R10 no irq on error", irq_cnt, 0);
        repeat (3) @(negedge clk);
        check(desc_ready == 0, "R10 command inactive after error", desc_ready, 0);

        // R12 and remainder cleared: fresh aligned read
        start_cmd(0, 50, 1);
        check(cmd_err == 0, "R12 start clears error", cmd_err, 0);
        do_desc(32'h1C00, 512);
        chk_stream(32'h1C00, 512, 50*512, "R10 remainder cleared by error");
        check(cmd_ok == 1, "R10 next command completes", cmd_ok, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule